// File: doc/BRIEF.md
# Lock-Gated Output Hold Controller

This block sits on the parallel output side of a deserializer. It keeps the recovered 24-bit data word, the three control bits and the forwarded clock at a defined low level until the link reports lock and software has released them. A hold-enable value is latched from a strap input each time the power pin rises. While the power pin is low, the output-enable is deasserted so the pads can float, because the strap has not been sampled yet.

Release and re-arm both come through a single-cycle register write port. A release or set request is honoured only while the synchronized lock is high; a request made while unlocked is dropped and not queued. A mode bit picks how the hold re-arms. In automatic mode a falling edge of lock re-arms it. In manual mode only a set write re-arms it, although a low lock still forces the outputs low. When the hold feature is strapped on, the alternative output-select request is suppressed.

The data path is a valid/ready stream. While outputs flow, valid and ready pass straight through. While outputs are forced low, `out_valid` is low and `in_ready` is high, so upstream words are drained and discarded and never stall.

Top module: `outhold_ctrl`

## Requirements
- R1: While the registered power pin is low, `out_oe` is 0 and `out_data`, `out_ctl`, `out_valid` are 0 (power-up state after reset included).
- R2: `stat_strap` takes the value of `strap_hold` on the clock after `pwr_on` rises, and later changes of `strap_hold` while powered have no effect on it.
- R3: With the hold strapped on, a low lock (seen two clocks later through the synchronizer) forces `out_data`, `out_ctl` and `out_valid` to 0 and sets `stat_held` to 1.
- R4: After power-up with the hold strapped on, the outputs stay forced low even with lock high until a release write is accepted.
- R5: A write with `wr_release`=1 while lock is high makes the outputs follow `in_data`, `in_ctl`, `in_valid` from the next clock, with `stat_held`=0.
- R6: A release write while lock is low is discarded: after lock returns high the outputs remain held.
- R7: In automatic mode (`wr_auto`=1), a falling edge of the synchronized lock re-arms the hold, so the outputs remain held after lock comes back.
- R8: In manual mode (`wr_auto`=0), a lock fall does not re-arm the hold; a `wr_set` write re-arms it only when made while lock is high, and `wr_set` wins over `wr_release` in the same write.
- R9: With the hold strapped off, the outputs follow the inputs whenever powered, independent of lock.
- R10: `alt_out` equals `alt_req` only when powered with the hold strapped off; otherwise it is 0.
- R11: `out_clk` is `clk` gated by an enable that changes only while `clk` is low; while held it stays low, while flowing it pulses with `clk`.
- R12: Stream rule: while held, `out_valid`=0 and `in_ready`=1 (words discarded); while flowing, `out_valid`=`in_valid` and `in_ready`=`out_ready`.
- R13: Reset selects automatic mode (`stat_mode`=1); any write updates the mode from `wr_auto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power pin, high = powered |
| strap_hold | input | 1 | Hold-enable strap, latched on power-up |
| lock_in | input | 1 | Asynchronous link-lock indication |
| wr_en | input | 1 | Register write strobe |
| wr_release | input | 1 | Release request bit of the write |
| wr_set | input | 1 | Re-arm request bit of the write |
| wr_auto | input | 1 | Mode bit: 1 automatic, 0 manual |
| alt_req | input | 1 | Alternative output-select request |
| in_data | input | 24 | Recovered data word |
| in_ctl | input | 3 | Recovered control bits |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| out_data | output | 24 | Gated data word |
| out_ctl | output | 3 | Gated control bits |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_clk | output | 1 | Gated output clock |
| out_oe | output | 1 | Output enable for the data, control and clock pads |
| alt_out | output | 1 | Effective alternative output-select |
| stat_held | output | 1 | Outputs currently forced low |
| stat_mode | output | 1 | Current re-arm mode, 1 = automatic |
| stat_strap | output | 1 | Latched hold-enable strap |

## Verification
On every cycle the assertions check several properties. Unpowered outputs are quiet. The strap value stays stable while powered. A lock that was low two clocks earlier forces the hold, and an unlocked release never frees the outputs. While held, the clock output stays low when sampled in its high phase and the stream drains. While flowing, the stream passes through, and the select request is blocked while the hold is strapped on. Some behaviour spans sequences of writes and lock transitions, and only the bench scenarios show it. This covers automatic re-arming after a lock loss, the absence of re-arming in manual mode, discarding of set writes made while unlocked, the reset default of the mode, and the change of behaviour across a power cycle with a different strap.

// File: rtl/outhold_pkg.sv
package outhold_pkg;
  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } rearm_mode_e;
endpackage

// File: rtl/oh_lock_sync.sv
module oh_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  output logic lock_s,
  output logic lock_fall
);
  logic [STAGES-1:0] sync_q;
  logic              lock_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lock_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lock_in};
      lock_d <= sync_q[STAGES-1];
    end
  end

  assign lock_s    = sync_q[STAGES-1];
  assign lock_fall = lock_d & ~lock_s;
endmodule

// File: rtl/oh_hold_fsm.sv
module oh_hold_fsm
  import outhold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_on,
  input  logic        strap_hold,
  input  logic        lock_s,
  input  logic        lock_fall,
  input  logic        wr_en,
  input  logic        wr_release,
  input  logic        wr_set,
  input  logic        wr_auto,
  output logic        pwr_q,
  output logic        strap_q,
  output logic        held_q,
  output rearm_mode_e mode_q
);
  logic set_ok, rel_ok;

  assign set_ok = wr_en & wr_set & lock_s;
  assign rel_ok = wr_en & wr_release & lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      strap_q <= 1'b0;
      held_q  <= 1'b1;
      mode_q  <= MODE_AUTO;
    end else begin
      pwr_q <= pwr_on;
      if (pwr_on && !pwr_q) strap_q <= strap_hold;
      if (wr_en) mode_q <= wr_auto ? MODE_AUTO : MODE_MANUAL;
      if (!pwr_q)                              held_q <= 1'b1;
      else if (set_ok)                         held_q <= 1'b1;
      else if (mode_q == MODE_AUTO && lock_fall) held_q <= 1'b1;
      else if (rel_ok)                         held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/oh_out_gate.sv
module oh_out_gate #(
  parameter int DATA_W = 24,
  parameter int CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_low,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTL_W-1:0]  in_ctl,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CTL_W-1:0]  out_ctl,
  output logic              out_valid,
  output logic              out_clk
);
  logic ck_en_q;

  // enable moves only on the falling edge, so the gated clock never runts
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ck_en_q <= 1'b0;
    else        ck_en_q <= ~force_low;
  end

  assign out_clk   = clk & ck_en_q;
  assign out_data  = force_low ? '0 : in_data;
  assign out_ctl   = force_low ? '0 : in_ctl;
  assign out_valid = in_valid & ~force_low;
  assign in_ready  = out_ready | force_low;
endmodule

// File: rtl/outhold_ctrl.sv
module outhold_ctrl
  import outhold_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CTL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              strap_hold,
  input  logic              lock_in,
  input  logic              wr_en,
  input  logic              wr_release,
  input  logic              wr_set,
  input  logic              wr_auto,
  input  logic              alt_req,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTL_W-1:0]  in_ctl,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CTL_W-1:0]  out_ctl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_clk,
  output logic              out_oe,
  output logic              alt_out,
  output logic              stat_held,
  output logic              stat_mode,
  output logic              stat_strap
);
  logic        lock_s, lock_fall;
  logic        pwr_q, strap_q, held_q, force_low;
  rearm_mode_e mode_q;

  oh_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in),
    .lock_s(lock_s), .lock_fall(lock_fall)
  );

  oh_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .strap_hold(strap_hold),
    .lock_s(lock_s), .lock_fall(lock_fall), .wr_en(wr_en),
    .wr_release(wr_release), .wr_set(wr_set), .wr_auto(wr_auto),
    .pwr_q(pwr_q), .strap_q(strap_q), .held_q(held_q), .mode_q(mode_q)
  );

  assign force_low = ~pwr_q | (strap_q & (held_q | ~lock_s));

  oh_out_gate #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .force_low(force_low),
    .in_data(in_data), .in_ctl(in_ctl), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .out_data(out_data),
    .out_ctl(out_ctl), .out_valid(out_valid), .out_clk(out_clk)
  );

  assign out_oe     = pwr_q;
  assign alt_out    = alt_req & pwr_q & ~strap_q;
  assign stat_held  = force_low;
  assign stat_mode  = (mode_q == MODE_AUTO);
  assign stat_strap = strap_q;
endmodule

// File: rtl/outhold_chk.sv
module outhold_chk #(
  parameter int DATA_W = 24,
  parameter int CTL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_in,
  input logic              wr_en,
  input logic              wr_release,
  input logic              alt_out,
  input logic [DATA_W-1:0] in_data,
  input logic [CTL_W-1:0]  in_ctl,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CTL_W-1:0]  out_ctl,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_clk,
  input logic              out_oe,
  input logic              stat_held,
  input logic              stat_strap
);
  p_unpowered_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_oe |-> (out_data == '0 && out_ctl == '0 && !out_valid));

  p_strap_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_oe && $past(out_oe)) |-> $stable(stat_strap));

  p_lock_low_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_oe && stat_strap && !$past(lock_in, 2)) |-> (stat_held && out_data == '0 && !out_valid));

  p_unlocked_release_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_oe && stat_strap && wr_en && wr_release && !$past(lock_in, 2)) |=> stat_held);

  p_alt_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strap |-> !alt_out);

  p_clk_quiet_r11: assert property (@(negedge clk) disable iff (!rst_n)
    (stat_held && $past(stat_held)) |-> !out_clk);

  p_held_drains_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_held |-> (!out_valid && in_ready));

  p_flow_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_oe && !stat_held) |-> (out_data == in_data && out_ctl == in_ctl &&
                                out_valid == in_valid && in_ready == out_ready));
endmodule

bind outhold_ctrl outhold_chk #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .wr_en(wr_en),
  .wr_release(wr_release), .alt_out(alt_out), .in_data(in_data),
  .in_ctl(in_ctl), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_ctl(out_ctl), .out_valid(out_valid),
  .out_ready(out_ready), .out_clk(out_clk), .out_oe(out_oe),
  .stat_held(stat_held), .stat_strap(stat_strap)
);

// File: tb/outhold_ctrl_bench.sv
module outhold_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n, pwr_on, strap_hold, lock_in;
  logic        wr_en, wr_release, wr_set, wr_auto, alt_req;
  logic [23:0] in_data;
  logic [2:0]  in_ctl;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [23:0] out_data;
  logic [2:0]  out_ctl;
  logic        out_clk, out_oe, alt_out, stat_held, stat_mode, stat_strap;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  outhold_ctrl u_outhold_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .strap_hold(strap_hold),
    .lock_in(lock_in), .wr_en(wr_en), .wr_release(wr_release),
    .wr_set(wr_set), .wr_auto(wr_auto), .alt_req(alt_req),
    .in_data(in_data), .in_ctl(in_ctl), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_ctl(out_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_clk(out_clk),
    .out_oe(out_oe), .alt_out(alt_out), .stat_held(stat_held),
    .stat_mode(stat_mode), .stat_strap(stat_strap)
  );

  // vector bits: [3] lock, [2] release write, [1] set write, [0] outputs flow
  localparam logic [3:0] VEC [10] = '{
    4'b0000,  // R3 unlocked after power-up: held
    4'b1000,  // R4 locked but not released: held
    4'b0100,  // R6 release while unlocked
    4'b1000,  // R6 relock: still held
    4'b1101,  // R5 release while locked: flows
    4'b0000,  // R3 lock lost: held
    4'b1000,  // R7 relock in auto mode: re-armed, held
    4'b1101,  // R5 release again
    4'b1010,  // R8 set while locked re-arms
    4'b1101   // R5 release
  };

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rel, input bit set, input bit auto_m);
    wr_en = 1'b1; wr_release = rel; wr_set = set; wr_auto = auto_m;
    tick(1);
    wr_en = 1'b0; wr_release = 1'b0; wr_set = 1'b0;
  endtask

  task automatic chk_flow(input string req, input bit flow);
    chk({req, " data"},  {8'h0, out_data}, flow ? {8'h0, in_data} : 32'h0);
    chk({req, " ctl"},   {29'h0, out_ctl}, flow ? {29'h0, in_ctl} : 32'h0);
    chk({req, " valid"}, {31'h0, out_valid}, flow ? {31'h0, in_valid} : 32'h0);
    chk({req, " held"},  {31'h0, stat_held}, {31'h0, ~flow});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_on = 1'b0; strap_hold = 1'b0; lock_in = 1'b0;
    wr_en = 1'b0; wr_release = 1'b0; wr_set = 1'b0; wr_auto = 1'b1;
    alt_req = 1'b0; in_data = 24'hC3A55A; in_ctl = 3'b101;
    in_valid = 1'b1; out_ready = 1'b1;
    tick(2);
    chk("R1 reset oe", {31'h0, out_oe}, 32'h0);
    chk_flow("R1 reset", 1'b0);
    chk("R13 reset mode auto", {31'h0, stat_mode}, 32'h1);
    chk("R12 reset drains", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    tick(2);
    chk("R1 unpowered oe", {31'h0, out_oe}, 32'h0);
    chk("R1 unpowered data", {8'h0, out_data}, 32'h0);

    strap_hold = 1'b1; pwr_on = 1'b1;
    tick(2);
    chk("R2 strap latched", {31'h0, stat_strap}, 32'h1);
    chk("R1 powered oe", {31'h0, out_oe}, 32'h1);
    strap_hold = 1'b0;
    tick(2);
    chk("R2 strap change ignored", {31'h0, stat_strap}, 32'h1);
    alt_req = 1'b1;
    #1;
    chk("R10 alt blocked when strapped", {31'h0, alt_out}, 32'h0);
    chk("R11 clk low while held", {31'h0, out_clk}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      lock_in = VEC[i][3];
      in_data = 24'h5A0F00 ^ (24'h010203 * (i + 1));
      tick(3);
      if (VEC[i][2] || VEC[i][1]) wr(VEC[i][2], VEC[i][1], 1'b1);
      else tick(1);
      chk_flow($sformatf("vector %0d", i), VEC[i][0]);
    end

    tick(2);
    chk("R11 clk pulses when flowing", {31'h0, out_clk}, 32'h1);
    out_ready = 1'b0;
    #1;
    chk("R12 flow backpressure", {31'h0, in_ready}, 32'h0);
    in_valid = 1'b0;
    #1;
    chk("R12 flow valid", {31'h0, out_valid}, 32'h0);
    in_valid = 1'b1; out_ready = 1'b1;

    wr(1'b0, 1'b0, 1'b0);
    chk("R13 write selects manual", {31'h0, stat_mode}, 32'h0);
    lock_in = 1'b0; tick(4);
    chk_flow("R3 manual unlocked", 1'b0);
    lock_in = 1'b1; tick(4);
    chk_flow("R8 manual no re-arm", 1'b1);
    lock_in = 1'b0; tick(4);
    wr(1'b0, 1'b1, 1'b0);
    lock_in = 1'b1; tick(4);
    chk_flow("R8 unlocked set discarded", 1'b1);
    wr(1'b1, 1'b1, 1'b0);
    chk_flow("R8 locked set wins", 1'b0);
    out_ready = 1'b0;
    #1;
    chk("R12 held drains", {31'h0, in_ready}, 32'h1);
    out_ready = 1'b1;
    wr(1'b1, 1'b0, 1'b0);
    chk_flow("R5 manual release", 1'b1);

    pwr_on = 1'b0; tick(2);
    chk("R1 power down oe", {31'h0, out_oe}, 32'h0);
    chk_flow("R1 power down", 1'b0);
    pwr_on = 1'b1; tick(2);
    chk("R2 strap off latched", {31'h0, stat_strap}, 32'h0);
    lock_in = 1'b0; tick(4);
    chk_flow("R9 strap off unlocked flows", 1'b1);
    chk("R10 alt follows request", {31'h0, alt_out}, 32'h1);
    alt_req = 1'b0;
    #1;
    chk("R10 alt follows low", {31'h0, alt_out}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule